// File: doc/BRIEF.md
# Operand Forwarding and Pipeline Hazard Control for a Five-Stage Y86 Core

This block is the purely combinational control heart of a five-stage Y86 pipeline. It sits beside the decode stage. For each of the two source operands it chooses the freshest value: either a result still in flight in the execute, memory or write-back stage, or the value read from the register file. It also produces the stall and bubble controls that the fetch, decode and execute pipeline registers obey.

Forwarding sources are searched in a fixed order, and the first match wins. The order is: the execute ALU result, the memory-stage load result, the memory-stage ALU result, the write-back load result, and the write-back ALU result. Inside one stage, the load result outranks the ALU result. This keeps `popl %esp` correct, because it writes the stack pointer from both ports in the same cycle.

The hazard side detects three conditions: a load/use dependency, a mispredicted conditional jump, and a return travelling down the pipe. From these it derives the four controls. The datapath registers themselves live outside this block.

Top module: `y86_fwd_hazard`

## Requirements
- R1: valB is taken from the first matching source in this order: e_valE (srcB equals e_dstE), m_valM (equals m_dstM), m_valE (equals m_dstE), w_valM (equals w_dstM), w_valE (equals w_dstE). With no match, valB is the register-file value d_rvalB.
- R2: When m_dstM and m_dstE both equal the source and no execute match exists, the output is m_valM, not m_valE.
- R3: When w_dstM and w_dstE both equal the source and no earlier match exists, the output is w_valM, not w_valE.
- R4: Register code 8 means "no register". A source of 8 never matches any destination, including a destination of 8, so the register-file value passes unchanged.
- R5: valA uses the same search order as valB. When d_icode is call (8) or jump (7), valA is d_valP regardless of any match.
- R6: A load/use hazard exists when e_icode is mrmovl (5) or popl (11), e_dstM is not 8, and e_dstM equals d_srcA or d_srcB. During it, d_stall, f_stall and e_bubble are all 1.
- R7: A mispredicted branch is e_icode jump (7) with e_taken 0. It sets e_bubble and d_bubble but neither stall. A taken jump raises no control.
- R8: A ret (9) in d_icode, e_icode or m_icode sets f_stall and d_bubble.
- R9: d_bubble is never 1 while d_stall is 1. A ret in decode during a load/use hazard gives d_stall 1 and d_bubble 0.
- R10: With no hazard condition present, all four controls are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_icode | input | 4 | Instruction code in decode |
| d_srcA | input | 4 | Decode source register A (8 = none) |
| d_srcB | input | 4 | Decode source register B (8 = none) |
| d_rvalA | input | WORD_W | Register-file read value for A |
| d_rvalB | input | WORD_W | Register-file read value for B |
| d_valP | input | WORD_W | Incremented PC of the decode instruction |
| e_icode | input | 4 | Instruction code in execute |
| e_dstE | input | 4 | Execute ALU destination |
| e_valE | input | WORD_W | Execute ALU result |
| e_dstM | input | 4 | Execute load destination |
| e_taken | input | 1 | Execute branch-taken flag |
| m_icode | input | 4 | Instruction code in memory |
| m_dstE | input | 4 | Memory-stage ALU destination |
| m_valE | input | WORD_W | Memory-stage ALU result |
| m_dstM | input | 4 | Memory-stage load destination |
| m_valM | input | WORD_W | Memory-stage load value |
| w_dstE | input | 4 | Write-back ALU destination |
| w_valE | input | WORD_W | Write-back ALU result |
| w_dstM | input | 4 | Write-back load destination |
| w_valM | input | WORD_W | Write-back load value |
| fwd_valA | output | WORD_W | Selected operand A |
| fwd_valB | output | WORD_W | Selected operand B |
| f_stall | output | 1 | Hold the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Insert a bubble into decode |
| e_bubble | output | 1 | Insert a bubble into execute |

## Verification
The in-RTL assertions check a set of relationships whenever the logic settles. Operand A equals valP on call and jump. A "none" source passes the register-file value through. An execute-stage match always wins. A load/use stall always comes with an execute bubble and a fetch stall, and never with a decode bubble. Every misprediction and every ret in flight produce their controls. The full priority ladder, including the load-over-ALU tie-breaks that protect `popl %esp`, can only be shown by the bench's scenarios. They peel matching sources away one by one and compare each output against a value chosen to be unique. The same holds for the absence of false stalls on unrelated loads.

// File: rtl/y86_hazard_pkg.sv
package y86_hazard_pkg;
   typedef enum logic [3:0] {
      IC_HALT   = 4'h0,
      IC_NOP    = 4'h1,
      IC_RRMOV  = 4'h2,
      IC_IRMOV  = 4'h3,
      IC_RMMOV  = 4'h4,
      IC_MRMOV  = 4'h5,
      IC_ALUOP  = 4'h6,
      IC_JUMP   = 4'h7,
      IC_CALL   = 4'h8,
      IC_RET    = 4'h9,
      IC_PUSH   = 4'hA,
      IC_POP    = 4'hB
   } icode_e;

   localparam int          ICODE_W  = 4;
   localparam int          REGID_W  = 4;
   localparam logic [3:0]  REG_NONE = 4'h8;
   // forwarding ladder, index 0 is searched first
   localparam int          FWD_SRCS = 5;
endpackage

// File: rtl/y86_opnd_fwd.sv
module y86_opnd_fwd
   import y86_hazard_pkg::*;
#(
   parameter int                 WORD_W  = 32,
   parameter int                 REG_W   = REGID_W,
   parameter int                 NSRC    = FWD_SRCS,
   parameter logic [REG_W-1:0]   NONE_ID = REG_NONE
) (
   input  logic [REG_W-1:0]               src,
   input  logic [WORD_W-1:0]              rf_val,
   input  logic [WORD_W-1:0]              pc_val,
   input  logic                           use_pc,
   input  logic [NSRC-1:0][REG_W-1:0]     dst_vec,
   input  logic [NSRC-1:0][WORD_W-1:0]    val_vec,
   output logic [WORD_W-1:0]              out_val
);
   localparam int LAST = NSRC - 1;

   generate
      if (NSRC < 1 || WORD_W < 1 || REG_W < 1) begin : g_bad_cfg
         $error("y86_opnd_fwd: illegal parameter set");
      end
   endgenerate

   logic [NSRC-1:0]   hit;
   logic [WORD_W-1:0] pick;

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_cmp
         assign hit[g] = (src != NONE_ID) && (dst_vec[g] == src);
      end
   endgenerate

   always_comb begin
      pick = rf_val;
      for (int i = LAST; i >= 0; i--) begin
         if (hit[i]) pick = val_vec[i];
      end
   end

   assign out_val = use_pc ? pc_val : pick;

   always_comb begin
      if (use_pc) begin
         a_r5_pc_select: assert (out_val == pc_val);
      end
      if (!use_pc && src == NONE_ID) begin
         a_r4_none_passes: assert (out_val == rf_val);
      end
      if (!use_pc && hit[0]) begin
         a_r1_newest_wins: assert (out_val == val_vec[0]);
      end
   end
endmodule

// File: rtl/y86_hazard_ctl.sv
module y86_hazard_ctl
   import y86_hazard_pkg::*;
#(
   parameter int               REG_W   = REGID_W,
   parameter logic [REG_W-1:0] NONE_ID = REG_NONE
) (
   input  logic [ICODE_W-1:0] d_icode,
   input  logic [REG_W-1:0]   d_srcA,
   input  logic [REG_W-1:0]   d_srcB,
   input  logic [ICODE_W-1:0] e_icode,
   input  logic [REG_W-1:0]   e_dstM,
   input  logic               e_taken,
   input  logic [ICODE_W-1:0] m_icode,
   output logic               f_stall,
   output logic               d_stall,
   output logic               d_bubble,
   output logic               e_bubble
);
   logic e_is_load, load_use, mispredict, ret_busy;

   assign e_is_load  = (e_icode == IC_MRMOV) || (e_icode == IC_POP);
   assign load_use   = e_is_load && (e_dstM != NONE_ID) &&
                       ((e_dstM == d_srcA) || (e_dstM == d_srcB));
   assign mispredict = (e_icode == IC_JUMP) && !e_taken;
   assign ret_busy   = (d_icode == IC_RET) || (e_icode == IC_RET) ||
                       (m_icode == IC_RET);

   assign d_stall  = load_use;
   assign f_stall  = load_use || ret_busy;
   assign e_bubble = load_use || mispredict;
   assign d_bubble = !load_use && (mispredict || ret_busy);

   always_comb begin
      a_r6_stall_pairs: assert (!d_stall || (e_bubble && f_stall));
      a_r9_no_stall_bubble: assert (!(d_stall && d_bubble));
      if (mispredict) begin
         a_r7_mispredict_flush: assert (e_bubble && d_bubble && !d_stall);
      end
      if (ret_busy) begin
         a_r8_ret_holds_fetch: assert (f_stall);
      end
   end
endmodule

// File: rtl/y86_fwd_hazard.sv
module y86_fwd_hazard
   import y86_hazard_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [3:0]        d_icode,
   input  logic [3:0]        d_srcA,
   input  logic [3:0]        d_srcB,
   input  logic [WORD_W-1:0] d_rvalA,
   input  logic [WORD_W-1:0] d_rvalB,
   input  logic [WORD_W-1:0] d_valP,
   input  logic [3:0]        e_icode,
   input  logic [3:0]        e_dstE,
   input  logic [WORD_W-1:0] e_valE,
   input  logic [3:0]        e_dstM,
   input  logic              e_taken,
   input  logic [3:0]        m_icode,
   input  logic [3:0]        m_dstE,
   input  logic [WORD_W-1:0] m_valE,
   input  logic [3:0]        m_dstM,
   input  logic [WORD_W-1:0] m_valM,
   input  logic [3:0]        w_dstE,
   input  logic [WORD_W-1:0] w_valE,
   input  logic [3:0]        w_dstM,
   input  logic [WORD_W-1:0] w_valM,
   output logic [WORD_W-1:0] fwd_valA,
   output logic [WORD_W-1:0] fwd_valB,
   output logic              f_stall,
   output logic              d_stall,
   output logic              d_bubble,
   output logic              e_bubble
);
   localparam int NS = FWD_SRCS;

   generate
      if (WORD_W < 8) begin : g_bad_word
         $error("y86_fwd_hazard: WORD_W too small");
      end
   endgenerate

   // priority order: load result ahead of ALU result within a stage
   logic [NS-1:0][REGID_W-1:0] dsts;
   logic [NS-1:0][WORD_W-1:0]  vals;
   logic                       a_takes_pc;

   assign dsts = {w_dstE, w_dstM, m_dstE, m_dstM, e_dstE};
   assign vals = {w_valE, w_valM, m_valE, m_valM, e_valE};

   assign a_takes_pc = (d_icode == IC_CALL) || (d_icode == IC_JUMP);

   y86_opnd_fwd #(.WORD_W(WORD_W), .REG_W(REGID_W), .NSRC(NS), .NONE_ID(REG_NONE))
   u_fwd_a (
      .src(d_srcA), .rf_val(d_rvalA), .pc_val(d_valP), .use_pc(a_takes_pc),
      .dst_vec(dsts), .val_vec(vals), .out_val(fwd_valA)
   );

   y86_opnd_fwd #(.WORD_W(WORD_W), .REG_W(REGID_W), .NSRC(NS), .NONE_ID(REG_NONE))
   u_fwd_b (
      .src(d_srcB), .rf_val(d_rvalB), .pc_val(d_valP), .use_pc(1'b0),
      .dst_vec(dsts), .val_vec(vals), .out_val(fwd_valB)
   );

   y86_hazard_ctl #(.REG_W(REGID_W), .NONE_ID(REG_NONE)) u_ctl (
      .d_icode(d_icode), .d_srcA(d_srcA), .d_srcB(d_srcB),
      .e_icode(e_icode), .e_dstM(e_dstM), .e_taken(e_taken),
      .m_icode(m_icode),
      .f_stall(f_stall), .d_stall(d_stall), .d_bubble(d_bubble),
      .e_bubble(e_bubble)
   );
endmodule

// File: tb/y86_fwd_hazard_bench.sv
module y86_fwd_hazard_bench;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [3:0]   d_icode, d_srcA, d_srcB, e_icode, e_dstE, e_dstM, m_icode;
   logic [3:0]   m_dstE, m_dstM, w_dstE, w_dstM;
   logic         e_taken;
   logic [W-1:0] d_rvalA, d_rvalB, d_valP, e_valE, m_valE, m_valM, w_valE, w_valM;
   logic [W-1:0] fwd_valA, fwd_valB;
   logic         f_stall, d_stall, d_bubble, e_bubble;

   int checks = 0;
   int errors = 0;

   y86_fwd_hazard #(.WORD_W(W)) u_y86_fwd_hazard (.*);

   task automatic chk_w(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_ctl(string tag, logic [3:0] exp);
      checks++;
      if ({f_stall, d_stall, d_bubble, e_bubble} !== exp) begin
         errors++;
         $display("FAIL %s actual fs/ds/db/eb=%b expected=%b", tag,
                  {f_stall, d_stall, d_bubble, e_bubble}, exp);
      end
   endtask

   task automatic idle();
      d_icode = 4'h1; e_icode = 4'h1; m_icode = 4'h1; e_taken = 1'b0;
      d_srcA = 4'h8; d_srcB = 4'h8;
      e_dstE = 4'h8; e_dstM = 4'h8; m_dstE = 4'h8; m_dstM = 4'h8;
      w_dstE = 4'h8; w_dstM = 4'h8;
      d_rvalA = 32'hAAAA_0001; d_rvalB = 32'hBBBB_0002; d_valP = 32'h0000_0123;
      e_valE = 32'hE0E0_0003; m_valM = 32'hD0D0_0004; m_valE = 32'hC0C0_0005;
      w_valM = 32'hB0B0_0006; w_valE = 32'hA0A0_0007;
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic t_idle();
      idle(); settle();
      chk_ctl("R10 idle controls", 4'b0000);
      chk_w("R4 idle valA", fwd_valA, 32'hAAAA_0001);
      chk_w("R4 idle valB", fwd_valB, 32'hBBBB_0002);
   endtask

   task automatic t_ladder_b();
      idle(); d_srcB = 4'h3;
      e_dstE = 4'h3; m_dstM = 4'h3; m_dstE = 4'h3; w_dstM = 4'h3; w_dstE = 4'h3;
      settle(); chk_w("R1 execute first", fwd_valB, 32'hE0E0_0003);
      e_dstE = 4'h8; settle(); chk_w("R2 mem load over mem alu", fwd_valB, 32'hD0D0_0004);
      m_dstM = 4'h8; settle(); chk_w("R1 mem alu", fwd_valB, 32'hC0C0_0005);
      m_dstE = 4'h8; settle(); chk_w("R3 wb load over wb alu", fwd_valB, 32'hB0B0_0006);
      w_dstM = 4'h2; settle(); chk_w("R1 wb alu", fwd_valB, 32'hA0A0_0007);
      w_dstE = 4'h1; settle(); chk_w("R1 register file", fwd_valB, 32'hBBBB_0002);
   endtask

   task automatic t_pop_sp_a();
      idle(); d_icode = 4'h2; d_srcA = 4'h4;
      m_dstE = 4'h4; m_dstM = 4'h4; settle();
      chk_w("R2 popl esp in memory", fwd_valA, 32'hD0D0_0004);
      m_dstE = 4'h8; m_dstM = 4'h8; w_dstE = 4'h4; w_dstM = 4'h4; settle();
      chk_w("R3 popl esp in write-back", fwd_valA, 32'hB0B0_0006);
      w_dstM = 4'h8; settle();
      chk_w("R5 valA wb alu", fwd_valA, 32'hA0A0_0007);
   endtask

   task automatic t_none();
      idle(); settle();
      chk_w("R4 none vs none dst B", fwd_valB, 32'hBBBB_0002);
      e_dstE = 4'h6; d_srcA = 4'h6; settle();
      chk_w("R4 real source still forwards", fwd_valA, 32'hE0E0_0003);
      chk_w("R4 none src B unaffected", fwd_valB, 32'hBBBB_0002);
   endtask

   task automatic t_valp();
      idle(); d_srcA = 4'h2; e_dstE = 4'h2; d_icode = 4'h8; settle();
      chk_w("R5 call picks valP", fwd_valA, 32'h0000_0123);
      d_icode = 4'h7; settle();
      chk_w("R5 jump picks valP", fwd_valA, 32'h0000_0123);
      d_icode = 4'h6; settle();
      chk_w("R5 alu op forwards", fwd_valA, 32'hE0E0_0003);
   endtask

   task automatic t_load_use();
      idle(); e_icode = 4'h5; e_dstM = 4'h5; d_srcB = 4'h5; settle();
      chk_ctl("R6 mrmovl on srcB", 4'b1101);
      idle(); e_icode = 4'hB; e_dstM = 4'h4; d_srcA = 4'h4; settle();
      chk_ctl("R6 popl on srcA", 4'b1101);
      idle(); e_icode = 4'h5; e_dstM = 4'h5; d_srcA = 4'h3; d_srcB = 4'h2; settle();
      chk_ctl("R6 unrelated load", 4'b0000);
      idle(); e_icode = 4'h6; e_dstM = 4'h5; d_srcA = 4'h5; settle();
      chk_ctl("R6 non-load in execute", 4'b0000);
   endtask

   task automatic t_mispredict();
      idle(); e_icode = 4'h7; e_taken = 1'b0; settle();
      chk_ctl("R7 not taken", 4'b0011);
      e_taken = 1'b1; settle();
      chk_ctl("R7 taken", 4'b0000);
   endtask

   task automatic t_ret();
      idle(); d_icode = 4'h9; settle(); chk_ctl("R8 ret in decode", 4'b1010);
      idle(); e_icode = 4'h9; settle(); chk_ctl("R8 ret in execute", 4'b1010);
      idle(); m_icode = 4'h9; settle(); chk_ctl("R8 ret in memory", 4'b1010);
   endtask

   task automatic t_combo();
      idle(); d_icode = 4'h9; d_srcA = 4'h4; e_icode = 4'hB; e_dstM = 4'h4; settle();
      chk_ctl("R9 ret with load/use", 4'b1101);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_ladder_b();
      t_pop_sp_a();
      t_none();
      t_valp();
      t_load_use();
      t_mispredict();
      t_ret();
      t_combo();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule